// File: doc/BRIEF.md
# Interrupt-Aware Fetch-Execute Sequencer

This block is the sequencing core of a small stored-program control unit. It keeps the program counter, the instruction register, an interrupt-enable flag, a supervisor/user mode bit and a halted state. It owns one word-addressed memory port with a request/ready handshake. It repeats a loop: read the word at the program counter, step the counter by one, and pass the word to an external execute unit that answers with a completion strobe and a few control flags. After each instruction completes it evaluates, in a single check cycle, whether to halt, return from an interrupt, dispatch a trap, enter an interrupt, or fetch the next instruction.

Interrupt entry needs no dedicated save register. The sequencer writes the return address to word 0 and then jumps indirectly through word 1. Traps switch to supervisor mode and jump indirectly through a table of vectors at a fixed base. The execute unit reports halt, interrupt enable, interrupt return, drop-to-user and trap requests together with its completion strobe.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is held and right after it, pc_o equals RESET_VECTOR, ie_o is 0, sup_o is 1, halted_o is 0, and the first memory access is a read at RESET_VECTOR.
- R2: An instruction fetch reads the word at the program counter and adds one to the counter. ex_start then stays high until ex_done, with ex_instr equal to the fetched word and pc_o equal to the fetch address plus one. ex_start and mem_req are never high in the same cycle.
- R3: irq is acted on only in the check cycle that follows ex_done. A request raised while an instruction executes starts no memory access before that instruction completes.
- R4: With irq high and ie_o set at the check cycle, the sequencer clears ie_o and writes the address of the next instruction to word 0. It then reads word 1 and loads the value into the program counter.
- R5: With irq high and ie_o clear at the check cycle, no interrupt is entered. The request stays pending until the flag is set.
- R6: ex_int_en reported with ex_done sets ie_o, and the setting already applies at that same instruction's check cycle.
- R7: ex_iret reported with ex_done reads word 0 into the program counter and sets ie_o.
- R8: ex_trap with number n reported with ex_done sets sup_o and loads the program counter from word TRAP_BASE+n. No other memory access comes between the check cycle and that read.
- R9: Priority at the check cycle is halt, then interrupt return, then trap, then interrupt. When a trap and an enabled interrupt meet, the trap is serviced first and the interrupt is entered at the check cycle of the next completed instruction.
- R10: ex_to_user reported with ex_done clears sup_o.
- R11: ex_halt reported with ex_done sets halted_o. From then on no memory request and no ex_start occur until reset.
- R12: An access holds mem_addr, mem_we and mem_wdata steady and keeps mem_req high until mem_ready. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data (saved program counter) |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| ex_start | output | 1 | Instruction handed to execute unit |
| ex_instr | output | DATA_W | Instruction register contents |
| ex_done | input | 1 | Execute unit finished |
| ex_halt | input | 1 | Halt request, with ex_done |
| ex_int_en | input | 1 | Enable interrupts, with ex_done |
| ex_iret | input | 1 | Return from interrupt, with ex_done |
| ex_to_user | input | 1 | Switch to user mode, with ex_done |
| ex_trap | input | 1 | Trap request, with ex_done |
| ex_trap_num | input | TRAP_W | Trap number, with ex_done |
| irq | input | 1 | Level interrupt request |
| pc_o | output | ADDR_W | Program counter |
| ie_o | output | 1 | Interrupt enable flag |
| sup_o | output | 1 | Supervisor mode bit |
| halted_o | output | 1 | Sequencer halted |

## Verification
A trap dispatch and an interrupt entry can both be due at the same check cycle. The bench provokes this by raising irq at the moment the trap instruction begins executing, while interrupts are enabled. The run is judged on the exact order of memory accesses: the trap table read must come first, then the fetch and execution of the handler's first instruction, and only then the save to word 0 and the read of word 1. The same program runs under every combination of memory and execute latency from 0 to 3 waits, so the decision never depends on the timing of the handshakes.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_EXEC,
      ST_CHECK,
      ST_SAVE,
      ST_VEC,
      ST_IRET,
      ST_TRAP,
      ST_HALT
   } seq_state_e;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_FETCH,
      ACC_SAVE,
      ACC_VEC,
      ACC_IRET,
      ACC_TRAP
   } seq_acc_e;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import seq_pkg::*;
#(
   parameter int TRAP_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_ready,
   input  logic              ex_done,
   input  logic              ex_halt,
   input  logic              ex_int_en,
   input  logic              ex_iret,
   input  logic              ex_to_user,
   input  logic              ex_trap,
   input  logic [TRAP_W-1:0] ex_trap_num,
   input  logic              irq_s,
   output seq_acc_e          acc,
   output logic [TRAP_W-1:0] trap_num_q,
   output logic              ex_start,
   output logic              ie,
   output logic              sup,
   output logic              halted
);

   seq_state_e state;
   logic       halt_q;
   logic       iret_q;
   logic       trap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_FETCH;
         ie         <= 1'b0;
         sup        <= 1'b1;
         halt_q     <= 1'b0;
         iret_q     <= 1'b0;
         trap_q     <= 1'b0;
         trap_num_q <= '0;
      end else begin
         unique case (state)
            ST_FETCH: if (mem_ready) state <= ST_EXEC;
            ST_EXEC: begin
               if (ex_done) begin
                  halt_q     <= ex_halt;
                  iret_q     <= ex_iret;
                  trap_q     <= ex_trap;
                  trap_num_q <= ex_trap_num;
                  if (ex_int_en)  ie  <= 1'b1;
                  if (ex_to_user) sup <= 1'b0;
                  state <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (halt_q) begin
                  state <= ST_HALT;
               end else if (iret_q) begin
                  state <= ST_IRET;
               end else if (trap_q) begin
                  sup   <= 1'b1;
                  state <= ST_TRAP;
               end else if (irq_s && ie) begin
                  ie    <= 1'b0;
                  state <= ST_SAVE;
               end else begin
                  state <= ST_FETCH;
               end
            end
            ST_SAVE: if (mem_ready) state <= ST_VEC;
            ST_VEC:  if (mem_ready) state <= ST_FETCH;
            ST_IRET: begin
               if (mem_ready) begin
                  ie    <= 1'b1;
                  state <= ST_FETCH;
               end
            end
            ST_TRAP: if (mem_ready) state <= ST_FETCH;
            default: state <= ST_HALT;
         endcase
      end
   end

   always_comb begin
      unique case (state)
         ST_FETCH: acc = ACC_FETCH;
         ST_SAVE:  acc = ACC_SAVE;
         ST_VEC:   acc = ACC_VEC;
         ST_IRET:  acc = ACC_IRET;
         ST_TRAP:  acc = ACC_TRAP;
         default:  acc = ACC_NONE;
      endcase
   end

   assign ex_start = (state == ST_EXEC);
   assign halted   = (state == ST_HALT);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
   import seq_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 16,
   parameter int TRAP_W       = 4,
   parameter int RESET_VECTOR = 16,
   parameter int TRAP_BASE    = 1000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  seq_acc_e          acc,
   input  logic [TRAP_W-1:0] trap_num,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] ir
);

   localparam logic [ADDR_W-1:0] SAVE_A  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] VEC_A   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] TBASE_A = ADDR_W'(TRAP_BASE);
   localparam logic [ADDR_W-1:0] RV_A    = ADDR_W'(RESET_VECTOR);

   always_comb begin
      mem_req   = (acc != ACC_NONE);
      mem_we    = (acc == ACC_SAVE);
      mem_wdata = DATA_W'(pc);
      unique case (acc)
         ACC_SAVE: mem_addr = SAVE_A;
         ACC_VEC:  mem_addr = VEC_A;
         ACC_IRET: mem_addr = SAVE_A;
         ACC_TRAP: mem_addr = TBASE_A + ADDR_W'(trap_num);
         default:  mem_addr = pc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= RV_A;
         ir <= '0;
      end else if (mem_ready) begin
         unique case (acc)
            ACC_FETCH: begin
               ir <= mem_rdata;
               pc <= pc + ADDR_W'(1);
            end
            ACC_VEC, ACC_IRET, ACC_TRAP: pc <= mem_rdata[ADDR_W-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
   import seq_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 16,
   parameter int TRAP_W       = 4,
   parameter int RESET_VECTOR = 16,
   parameter int TRAP_BASE    = 1000,
   parameter int IRQ_SYNC     = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              ex_start,
   output logic [DATA_W-1:0] ex_instr,
   input  logic              ex_done,
   input  logic              ex_halt,
   input  logic              ex_int_en,
   input  logic              ex_iret,
   input  logic              ex_to_user,
   input  logic              ex_trap,
   input  logic [TRAP_W-1:0] ex_trap_num,
   input  logic              irq,
   output logic [ADDR_W-1:0] pc_o,
   output logic              ie_o,
   output logic              sup_o,
   output logic              halted_o
);

   localparam longint ADDR_SPAN = longint'(1) << ADDR_W;
   localparam longint TRAP_END  = longint'(TRAP_BASE) + (longint'(1) << TRAP_W);

   if (DATA_W < ADDR_W) begin : g_err_width
      $error("data word must hold a full address");
   end
   if (TRAP_END > ADDR_SPAN) begin : g_err_trap
      $error("trap table exceeds address space");
   end
   if (longint'(RESET_VECTOR) >= ADDR_SPAN || TRAP_BASE < 2) begin : g_err_vec
      $error("reset vector or trap base out of range");
   end

   logic     irq_s;
   seq_acc_e acc;
   logic [TRAP_W-1:0] trap_num_q;

   if (IRQ_SYNC == 0) begin : g_irq_direct
      assign irq_s = irq;
   end else begin : g_irq_sync
      logic [IRQ_SYNC-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[IRQ_SYNC-1:0] , irq} >> 0 == 0 ? '0 : IRQ_SYNC'({sync_q, irq});
      end
      assign irq_s = sync_q[IRQ_SYNC-1];
   end

   seq_ctrl #(.TRAP_W(TRAP_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mem_ready   (mem_ready),
      .ex_done     (ex_done),
      .ex_halt     (ex_halt),
      .ex_int_en   (ex_int_en),
      .ex_iret     (ex_iret),
      .ex_to_user  (ex_to_user),
      .ex_trap     (ex_trap),
      .ex_trap_num (ex_trap_num),
      .irq_s       (irq_s),
      .acc         (acc),
      .trap_num_q  (trap_num_q),
      .ex_start    (ex_start),
      .ie          (ie_o),
      .sup         (sup_o),
      .halted      (halted_o)
   );

   seq_datapath #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .TRAP_W       (TRAP_W),
      .RESET_VECTOR (RESET_VECTOR),
      .TRAP_BASE    (TRAP_BASE)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .trap_num  (trap_num_q),
      .mem_ready (mem_ready),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .pc        (pc_o),
      .ir        (ex_instr)
   );

endmodule

module seq_checker #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 16,
   parameter int TRAP_BASE = 1000
)(
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ready,
   input logic              ex_start,
   input logic              ie_o,
   input logic              sup_o,
   input logic              halted_o
);

   a_r12_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(ex_start && mem_req));

   a_r4_save_at_word0: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr == ADDR_W'(0) && !ie_o));

   a_r4_vector_follows_save: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we && mem_addr == ADDR_W'(1)));

   a_r8_trap_table_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sup_o) |-> (mem_req && !mem_we && mem_addr >= ADDR_W'(TRAP_BASE)));

   a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> (halted_o && !mem_req && !ex_start));

endmodule

bind fetch_exec_seq seq_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .TRAP_BASE (TRAP_BASE)
) u_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .ex_start  (ex_start),
   .ie_o      (ie_o),
   .sup_o     (sup_o),
   .halted_o  (halted_o)
);

// File: tb/tb_fetch_exec_seq.sv
module tb_fetch_exec_seq;

   localparam int AW = 11;
   localparam int DW = 16;
   localparam int TW = 4;
   localparam int RV = 16;
   localparam int TB = 1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_ready = 1'b0;
   logic          ex_start;
   logic [DW-1:0] ex_instr;
   logic          ex_done = 1'b0, ex_halt = 1'b0, ex_int_en = 1'b0;
   logic          ex_iret = 1'b0, ex_to_user = 1'b0, ex_trap = 1'b0;
   logic [TW-1:0] ex_trap_num = '0;
   logic          irq = 1'b0;
   logic [AW-1:0] pc_o;
   logic          ie_o, sup_o, halted_o;

   always #2 clk = ~clk;

   fetch_exec_seq #(
      .ADDR_W(AW), .DATA_W(DW), .TRAP_W(TW), .RESET_VECTOR(RV), .TRAP_BASE(TB), .IRQ_SYNC(0)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .ex_start(ex_start), .ex_instr(ex_instr), .ex_done(ex_done), .ex_halt(ex_halt),
      .ex_int_en(ex_int_en), .ex_iret(ex_iret), .ex_to_user(ex_to_user), .ex_trap(ex_trap),
      .ex_trap_num(ex_trap_num), .irq(irq),
      .pc_o(pc_o), .ie_o(ie_o), .sup_o(sup_o), .halted_o(halted_o)
   );

   int checks = 0;
   int failures = 0;

   logic [DW-1:0] mem [0:2047];

   int ac_addr [0:31];
   bit ac_we   [0:31];
   int ac_wd   [0:31];
   int n_acc;
   int st_addr [0:15];
   bit st_sup  [0:15];
   bit st_ie   [0:15];
   int n_st;
   int m_cnt, e_cnt;
   int h_addr, h_wd;
   bit h_we;

   int exp_sa  [10] = '{16, 17, 100, 101, 18, 19, 300, 100, 101, 301};
   bit exp_sup [10] = '{1, 1, 1, 1, 1, 0, 1, 1, 1, 1};
   bit exp_ie  [10] = '{0, 0, 0, 0, 1, 1, 1, 0, 0, 1};
   int exp_aa  [17] = '{16, 17, 0, 1, 100, 101, 0, 18, 19, 1003, 300, 0, 1, 100, 101, 0, 301};
   bit exp_aw  [17] = '{0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_program();
      for (int i = 0; i < 2048; i++) mem[i] = '0;
      mem[1]    = 16'd100;
      for (int k = 0; k < 16; k++) mem[TB + k] = 16'(500 + k);
      mem[1003] = 16'd300;
      mem[16]   = 16'h0051;  // plain
      mem[17]   = 16'h4000;  // enable interrupts
      mem[18]   = 16'h1000;  // drop to user
      mem[19]   = 16'h0803;  // trap 3
      mem[100]  = 16'h0052;  // plain
      mem[101]  = 16'h2000;  // return from interrupt
      mem[300]  = 16'h0053;  // plain
      mem[301]  = 16'h8000;  // halt
   endtask

   // one negedge: observe outputs, then drive memory and execute responses
   task automatic step(input int ml, input int el);
      if (mem_req) begin
         if (m_cnt == 0) begin
            h_addr = int'(mem_addr); h_we = mem_we; h_wd = int'(mem_wdata);
         end else begin
            chk(int'(mem_addr) == h_addr && mem_we == h_we && int'(mem_wdata) == h_wd,
                "R12 access held", int'(mem_addr), h_addr);
         end
         if (m_cnt >= ml) begin
            mem_ready = 1'b1;
            mem_rdata = mem[mem_addr];
            if (mem_we) mem[mem_addr] = mem_wdata;
            if (n_acc < 32) begin
               ac_addr[n_acc] = int'(mem_addr); ac_we[n_acc] = mem_we; ac_wd[n_acc] = int'(mem_wdata);
            end
            n_acc++;
            m_cnt = 0;
         end else begin
            mem_ready = 1'b0;
            m_cnt++;
         end
      end else begin
         if (m_cnt != 0) chk(1'b0, "R12 request dropped early", 0, 1);
         mem_ready = 1'b0;
         m_cnt = 0;
      end

      if (ex_start) begin
         if (e_cnt == 0) begin
            int a;
            a = (n_acc > 0 && n_acc <= 32) ? ac_addr[n_acc-1] : -1;
            chk(int'(ex_instr) == int'(mem[a[AW-1:0]]), "R2 ex_instr is fetched word", int'(ex_instr), int'(mem[a[AW-1:0]]));
            chk(int'(pc_o) == a + 1, "R2 pc advanced by one", int'(pc_o), a + 1);
            if (n_st < 16) begin
               st_addr[n_st] = a; st_sup[n_st] = sup_o; st_ie[n_st] = ie_o;
            end
            n_st++;
            if (a == 16 || a == 19) irq = 1'b1;
            if (a == 101) irq = 1'b0;
         end
         if (e_cnt >= el) begin
            ex_done     = 1'b1;
            ex_halt     = ex_instr[15];
            ex_int_en   = ex_instr[14];
            ex_iret     = ex_instr[13];
            ex_to_user  = ex_instr[12];
            ex_trap     = ex_instr[11];
            ex_trap_num = ex_instr[3:0];
            e_cnt = 0;
         end else begin
            ex_done = 1'b0;
            e_cnt++;
         end
      end else begin
         ex_done = 1'b0; ex_halt = 1'b0; ex_int_en = 1'b0; ex_iret = 1'b0;
         ex_to_user = 1'b0; ex_trap = 1'b0; ex_trap_num = '0;
         e_cnt = 0;
      end
   endtask

   task automatic run_one(input int ml, input int el);
      int cyc;
      rst_n = 1'b0;
      irq = 1'b0; mem_ready = 1'b0; ex_done = 1'b0;
      n_acc = 0; n_st = 0; m_cnt = 0; e_cnt = 0;
      load_program();
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk(int'(pc_o) == RV, "R1 pc at reset", int'(pc_o), RV);
      chk(ie_o == 1'b0 && halted_o == 1'b0, "R1 ie and halted clear", int'({ie_o, halted_o}), 0);
      chk(sup_o == 1'b1, "R1 supervisor at reset", int'(sup_o), 1);
      chk(mem_req && !mem_we && int'(mem_addr) == RV, "R1 first fetch address", int'(mem_addr), RV);
      rst_n = 1'b1;
      cyc = 0;
      while (!halted_o && cyc < 3000) begin
         @(negedge clk);
         step(ml, el);
         cyc++;
      end
      chk(cyc < 3000, "R11 reaches halt", cyc, 3000);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         step(ml, el);
         chk(!mem_req && !ex_start && halted_o, "R11 quiet after halt", int'({mem_req, ex_start, halted_o}), 1);
      end
      chk(n_st == 10, "R3 executed instruction count", n_st, 10);
      chk(n_acc == 17, "R4 access count", n_acc, 17);
      for (int i = 0; i < 10; i++) begin
         if (i < n_st) begin
            chk(st_addr[i] == exp_sa[i], "R9 instruction order", st_addr[i], exp_sa[i]);
            chk(st_sup[i] == exp_sup[i], "R10 mode at start", int'(st_sup[i]), int'(exp_sup[i]));
            chk(st_ie[i] == exp_ie[i], "R6 enable at start", int'(st_ie[i]), int'(exp_ie[i]));
         end
      end
      for (int i = 0; i < 17; i++) begin
         if (i < n_acc) begin
            chk(ac_addr[i] == exp_aa[i], "R8 access address order", ac_addr[i], exp_aa[i]);
            chk(ac_we[i] == exp_aw[i], "R4 access direction", int'(ac_we[i]), int'(exp_aw[i]));
         end
      end
      if (n_acc >= 12) begin
         chk(ac_wd[2] == 18, "R4 saved return address", ac_wd[2], 18);
         chk(ac_wd[11] == 301, "R9 saved address after trap", ac_wd[11], 301);
      end
      chk(int'(pc_o) == 302, "R11 pc after halt", int'(pc_o), 302);
      chk(ie_o == 1'b1, "R7 enable restored", int'(ie_o), 1);
      chk(sup_o == 1'b1, "R8 supervisor after trap", int'(sup_o), 1);
      chk(int'(mem[0]) == 301, "R5 word0 holds last save", int'(mem[0]), 301);
   endtask

   initial begin
      for (int ml = 0; ml < 4; ml++) begin
         for (int el = 0; el < 4; el++) begin
            run_one(ml, el);
         end
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule